// File: doc/BRIEF.md
# Composite Sync Separator with Horizontal Pulse Reinsertion

This block takes a raw composite sync line, carrying both horizontal and vertical timing, and produces two clean positive-going outputs: a horizontal sync that keeps running through the vertical interval and a separated vertical sync. The input may idle high or low. The block works out which level is the idle level and inverts the input when needed, so all further logic sees active-high pulses.

Vertical sync is recovered with a width filter. A pulse counts as vertical only after it has stayed active for 8 us. The output then holds for another 8 us after the input falls, so the separated vertical pulse is shifted and stretched by that amount. Between vertical pulses the block counts the short, horizontal-width pulses and keeps that number as the frame's line total.

In the next frame, incoming pulses are passed through until the running count reaches the stored total. From then until the separated vertical sync ends, raw pulses are blocked. In their place the block emits 2 us synthetic pulses, spaced by the interval measured between the last two pulses it passed. Holding the enable low gives pure pass-through of the normalised input with vertical sync held low.

Top module: `csync_separator`

## Requirements
- R1: The idle level is the level held for the majority of a window of 2^POL_WIN_LOG2 cycles. When the input is mostly high, `pol_neg_o` reads 1 after the window ends and the outputs show the inverted (active-high) pulses. The flag changes only at a window boundary.
- R2: A normalised pulse shorter than the 8 us threshold (VMIN cycles) never asserts `vsync_o`.
- R3: `vsync_o` rises VMIN cycles after the normalised input rises, if the input is still high. It falls VMIN cycles after the input falls, so the output is delayed and widened by the threshold.
- R4: While `vsync_o` is low, each short pulse ends with an increment of a line counter. At the rising edge of `vsync_o`, a nonzero count is kept as the frame line total, provided one vertical falling edge has already been seen.
- R5: While no insertion is active, `hsync_o` equals the normalised input delayed by one register stage. Raw pulses therefore appear three clocks after the input.
- R6: Insertion turns on when the running count reaches the stored total. Raw pulses are blocked from then on, and insertion turns off in the cycle after `vsync_o` falls.
- R7: Inserted pulses repeat with the interval measured between the rising edges of the last two passed pulses. The first one starts that interval after the last passed pulse.
- R8: Every inserted pulse lasts exactly 2 us (WCYC cycles). A new one never starts while the previous one is still high.
- R9: After reset, or after the enable has been low, no insertion happens until a full frame bounded by two vertical pulses has stored a line total. Insertion starts in the frame after that.
- R10: With `en_i` low, `hsync_o` follows the normalised input, `vsync_o` is low from the next cycle on, and all learned frame state is cleared.
- R11: During and right after reset, `hsync_o`, `vsync_o` and `pol_neg_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all timing thresholds are derived from CLK_HZ |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | 1 = separate and reinsert; 0 = plain pass-through, vertical low |
| csync_i | input | 1 | Raw composite sync, either polarity |
| hsync_o | output | 1 | Positive horizontal sync, raw or synthesised |
| vsync_o | output | 1 | Positive separated vertical sync |
| pol_neg_o | output | 1 | 1 when the input was found to idle high |

## Verification
Two things coincide at the start of the vertical pulse. A raw rising edge arrives, and it would be passed under R5. In the same clock slot the first synthetic pulse is due under R7, because the vertical pulse begins one line period after the last passed pulse. The bench drives frames whose vertical pulse starts exactly on the line grid and samples `hsync_o` at fixed offsets from that edge. In an inserting frame, the output must be high only inside the synthetic 2 us windows and low while the raw vertical pulse is still active between them. In a frame that is not yet armed, the output must follow the raw pulse instead. Running the same frames with two different line periods shows that the spacing follows the measured interval.

// File: rtl/csep_pkg.sv
package csep_pkg;

  // Number of clock cycles in a time span given in nanoseconds.
  function automatic int unsigned ns_to_cycles(longint unsigned clk_hz, longint unsigned span_ns);
    longint unsigned prod;
    prod = (clk_hz / 64'd1000) * span_ns / 64'd1000000;
    return prod[31:0];
  endfunction

  localparam longint unsigned VFILT_NS = 64'd8000;
  localparam longint unsigned HPULSE_NS = 64'd2000;

endpackage

// File: rtl/csep_polarity.sv
module csep_polarity #(
  parameter int unsigned WIN_LOG2 = 18
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic norm_o,
  output logic pol_o
);
  localparam int unsigned ACC_W = WIN_LOG2 + 1;
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (WIN_LOG2 - 1);

  logic                raw_q;
  logic [WIN_LOG2-1:0] win_cnt;
  logic [ACC_W-1:0]    hi_acc;
  logic [ACC_W-1:0]    hi_next;

  assign hi_next = hi_acc + ACC_W'(raw_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      raw_q   <= 1'b0;
      norm_o  <= 1'b0;
      pol_o   <= 1'b0;
      win_cnt <= '0;
      hi_acc  <= '0;
    end else begin
      raw_q   <= raw_i;
      norm_o  <= raw_q ^ pol_o;
      win_cnt <= win_cnt + 1'b1;
      if (&win_cnt) begin
        pol_o  <= (hi_next > HALF);
        hi_acc <= '0;
      end else begin
        hi_acc <= hi_next;
      end
    end
  end

  AST_POL_AT_WINDOW_END: assert property (@(posedge clk_i) disable iff (rst_i)
    (pol_o != $past(pol_o)) |-> $past(&win_cnt)) else $error("polarity moved mid-window"); // R1

endmodule

// File: rtl/csep_vsep.sv
module csep_vsep #(
  parameter int unsigned VMIN = 1600
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic norm_i,
  output logic vs_o,
  output logic hend_o
);
  localparam int unsigned HI_W = $clog2(VMIN + 1);
  localparam logic [HI_W-1:0] VMAX = HI_W'(VMIN);
  localparam logic [HI_W-1:0] VLAST = HI_W'(VMIN - 1);

  logic            norm_d;
  logic [HI_W-1:0] hi_cnt;
  logic [HI_W-1:0] hold_cnt;

  // end of a pulse that stayed shorter than the vertical threshold
  assign hend_o = en_i && norm_d && !norm_i && (hi_cnt < VMAX);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      norm_d   <= 1'b0;
      hi_cnt   <= '0;
      hold_cnt <= '0;
      vs_o     <= 1'b0;
    end else begin
      norm_d <= norm_i;
      if (!norm_i)               hi_cnt <= '0;
      else if (hi_cnt != VMAX)   hi_cnt <= hi_cnt + 1'b1;

      if (!en_i) begin
        vs_o     <= 1'b0;
        hold_cnt <= '0;
      end else if (!vs_o) begin
        hold_cnt <= '0;
        if (norm_i && hi_cnt == VLAST) vs_o <= 1'b1;
      end else if (norm_i) begin
        hold_cnt <= '0;
      end else if (hold_cnt == VLAST) begin
        vs_o     <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  AST_VS_RISE_ON_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(vs_o) |-> $past(norm_i)) else $error("vsync rose on a low input"); // R2
  AST_VS_FALL_ON_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(vs_o) && $past(en_i)) |-> !$past(norm_i)) else $error("vsync fell on a high input"); // R3

endmodule

// File: rtl/csep_hins.sv
module csep_hins #(
  parameter int unsigned WCYC  = 400,
  parameter int unsigned PER_W = 16,
  parameter int unsigned CNT_W = 12
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic norm_i,
  input  logic vs_i,
  input  logic hend_i,
  output logic hs_o
);
  localparam int unsigned WW = $clog2(WCYC + 1);
  localparam logic [WW-1:0] WLAST = WW'(WCYC - 1);
  localparam logic [PER_W-1:0] PMIN = PER_W'(WCYC);

  logic             norm_d, vs_d;
  logic [PER_W-1:0] gap, period;
  logic [WW-1:0]    wcnt;
  logic [CNT_W-1:0] cnt, nh;
  logic             nh_valid, framed, armed;
  logic             rise, ins, start;

  assign rise  = norm_i && !norm_d;
  assign ins   = armed && (cnt >= nh);
  assign start = ins && (period > PMIN) && (gap == period - PER_W'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      norm_d   <= rst_i ? 1'b0 : norm_i;
      hs_o     <= rst_i ? 1'b0 : norm_i;
      vs_d     <= 1'b0;
      gap      <= '0;
      period   <= '0;
      wcnt     <= '0;
      cnt      <= '0;
      nh       <= '0;
      nh_valid <= 1'b0;
      framed   <= 1'b0;
      armed    <= 1'b0;
    end else begin
      norm_d <= norm_i;
      vs_d   <= vs_i;

      // interval between passed edges, and synthetic pulse spacing
      if (rise && !ins) begin
        period <= (&gap) ? gap : gap + 1'b1;
        gap    <= '0;
      end else if (start) begin
        gap <= '0;
      end else if (!(&gap)) begin
        gap <= gap + 1'b1;
      end

      if (start)             wcnt <= WLAST;
      else if (wcnt != '0)   wcnt <= wcnt - 1'b1;

      // per-frame line bookkeeping
      if (vs_d && !vs_i) begin
        cnt    <= '0;
        framed <= 1'b1;
        armed  <= nh_valid;
      end else if (!vs_d && vs_i) begin
        if (framed && cnt != '0) begin
          nh       <= cnt;
          nh_valid <= 1'b1;
        end
      end else if (hend_i && !vs_i && !(&cnt)) begin
        cnt <= cnt + 1'b1;
      end

      hs_o <= ins ? (start || wcnt != '0) : norm_i;
    end
  end

  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(ins) |-> (hs_o == $past(norm_i))) else $error("pass-through mismatch"); // R5
  AST_INS_ENDS_WITH_VS: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(vs_i) |=> !ins) else $error("insertion outlived vsync"); // R6
  AST_NO_PULSE_OVERLAP: assert property (@(posedge clk_i) disable iff (rst_i)
    start |-> (wcnt == '0)) else $error("synthetic pulses overlap"); // R8
  AST_NH_LEARNED: assert property (@(posedge clk_i) disable iff (rst_i || !en_i)
    ($rose(vs_i) && framed && cnt != '0) |=> nh_valid) else $error("line total not kept"); // R4

endmodule

// File: rtl/csync_separator.sv
module csync_separator #(
  parameter int unsigned CLK_HZ       = 200_000_000,
  parameter int unsigned POL_WIN_LOG2 = 18,
  parameter int unsigned PER_W        = 16,
  parameter int unsigned CNT_W        = 12
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic csync_i,
  output logic hsync_o,
  output logic vsync_o,
  output logic pol_neg_o
);
  localparam int unsigned VMIN = csep_pkg::ns_to_cycles(64'(CLK_HZ), csep_pkg::VFILT_NS);
  localparam int unsigned WCYC = csep_pkg::ns_to_cycles(64'(CLK_HZ), csep_pkg::HPULSE_NS);

  logic norm, hend;

  csep_polarity #(.WIN_LOG2(POL_WIN_LOG2)) u_pol (
    .clk_i (clk_i), .rst_i (rst_i), .raw_i (csync_i),
    .norm_o(norm), .pol_o (pol_neg_o)
  );

  csep_vsep #(.VMIN(VMIN)) u_vsep (
    .clk_i (clk_i), .rst_i (rst_i), .en_i (en_i), .norm_i(norm),
    .vs_o  (vsync_o), .hend_o(hend)
  );

  csep_hins #(.WCYC(WCYC), .PER_W(PER_W), .CNT_W(CNT_W)) u_hins (
    .clk_i (clk_i), .rst_i (rst_i), .en_i (en_i), .norm_i(norm),
    .vs_i  (vsync_o), .hend_i(hend), .hs_o (hsync_o)
  );

  AST_DISABLED_NO_VS: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> !vsync_o) else $error("vsync active while disabled"); // R10

endmodule

// File: tb/test_csync_separator.sv
`timescale 1ns/1ps
module test_csync_separator;
  // scaled time base: 4 MHz parameter gives 32-cycle filter and 8-cycle pulses
  localparam int unsigned LINES = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b1;
  logic act = 1'b0;
  logic neg = 1'b0;
  logic csync;
  logic hs, vs, pol;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  int   now = 0;

  assign csync = act ^ neg;
  always #2.5 clk = ~clk;

  csync_separator #(.CLK_HZ(4_000_000), .POL_WIN_LOG2(10)) i_csync_separator (
    .clk_i(clk), .rst_i(rst), .en_i(en), .csync_i(csync),
    .hsync_o(hs), .vsync_o(vs), .pol_neg_o(pol)
  );

  // frame table: {insertion expected, line period}
  localparam logic [8:0] FRAME_TAB [4] = '{
    {1'b0, 8'd100}, {1'b0, 8'd100}, {1'b1, 8'd100}, {1'b1, 8'd120}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
    now += n;
  endtask

  task automatic go(input int t);
    step(t - now);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic line(input int len);
    now = 0;
    act = 1'b1;
    go(4);  chk(hs, 1'b1, "R5 raw line passed");
            chk(vs, 1'b0, "R2 short pulse no vsync");
    go(8);  act = 1'b0;
    go(50); chk(hs, 1'b0, "R5 line low");
    go(len);
  endtask

  task automatic vert(input int per, input bit ins, input string ptag);
    now = 0;
    act = 1'b1;
    go(6);   chk(hs, 1'b1, "R8 first pulse or raw edge");
    go(20);  chk(vs, 1'b0, "R3 vsync not yet");
             chk(hs, ins ? 1'b0 : 1'b1, ins ? "R6 raw vertical blocked" : ptag);
    go(50);  chk(vs, 1'b1, "R3 vsync after threshold");
    if (ins) begin
      go(per - 10);  chk(hs, 1'b0, "R7 gap before second pulse");
      go(per + 6);   chk(hs, 1'b1, "R7 second pulse at measured period");
      go(per + 10);  chk(hs, 1'b1, "R8 pulse still high at last cycle");
      go(per + 11);  chk(hs, 1'b0, "R8 pulse width");
    end else begin
      go(150); chk(hs, 1'b1, ptag);
    end
    go(300); act = 1'b0;
    go(320); chk(vs, 1'b1, "R3 vsync widened");
    go(350); chk(vs, 1'b0, "R3 vsync ended");
             chk(hs, 1'b0, "R6 insertion off after vsync");
    go(400);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(5);
    chk(hs, 1'b0, "R11 reset hsync");
    chk(vs, 1'b0, "R11 reset vsync");
    chk(pol, 1'b0, "R11 reset polarity");
    rst = 1'b0;
    step(3);
    chk(hs, 1'b0, "R11 hsync after reset");
    chk(pol, 1'b0, "R11 polarity after reset");
    step(20);

    // table walk: learn, arm, insert at two periods
    for (int f = 0; f < 4; f++) begin
      for (int l = 0; l < LINES; l++) line(int'(FRAME_TAB[f][7:0]));
      vert(int'(FRAME_TAB[f][7:0]), FRAME_TAB[f][8], "R9 raw vertical passed");
    end

    // disabled: pure pass-through, no vsync
    en = 1'b0;
    now = 0;
    act = 1'b1;
    go(50);  chk(vs, 1'b0, "R10 vsync held low");
    go(150); chk(hs, 1'b1, "R10 raw passed while disabled");
    go(300); act = 1'b0;
    go(400);
    en = 1'b1;
    step(5);

    // after re-enable no insertion until a new frame is learned
    for (int l = 0; l < LINES; l++) line(100);
    vert(100, 1'b0, "R9 no insertion after re-enable");

    // inverted input
    rst = 1'b1;
    neg = 1'b1;
    act = 1'b0;
    step(4);
    rst = 1'b0;
    step(1100);
    chk(pol, 1'b1, "R1 idle-high input detected");
    chk(hs, 1'b0, "R1 normalised idle low");
    chk(vs, 1'b0, "R1 no vsync at idle");
    for (int l = 0; l < 2; l++) line(100);
    chk(pol, 1'b1, "R1 polarity stable over lines");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule